// File: doc/BRIEF.md
# Network Link and Activity Indicator Driver

This block turns the status signals of a 10/100 network port into two indicator outputs. One output, the link indicator, is dark when there is no link. It is lit steadily when a link is up and the port is idle, and it blinks while frames are moving. The other output, the speed indicator, is lit only for a 100 Mb/s link. A transmit or receive strobe lasts a single cycle, so each strobe reloads a stretch timer and the blink pattern runs until that timer runs out. This keeps even a single short frame visible.

All four status inputs pass through two-flop synchronizers. Activity that arrives while the link is down is discarded, and a loss of link clears any stretch that is still running. Three parameters set the timing: the system clock frequency, the stretch length in milliseconds and the blink rate in hertz. Package functions convert these into cycle counts.

Top module: `eth_led_driver`

## Requirements
- R1: A change on `link_up_i` or `speed_100_i` reaches the indicator outputs after exactly two rising clock edges, and not after one.
- R2: While the synchronized link status is low, `led_link_o` is 0.
- R3: While the link is up and no stretch is running, `led_link_o` is steadily 1.
- R4: A transmit or receive strobe seen with the link up loads a stretch of STRETCH = CLK_HZ*STRETCH_MS/1000 cycles. The first edge after the synchronized strobe starts it. During the stretch the indicator starts dark, and it returns to steady 1 once the timer reaches zero.
- R5: While a stretch runs, `led_link_o` toggles every HALF = CLK_HZ/(2*BLINK_HZ) cycles. The first toggle comes HALF cycles after the stretch begins.
- R6: A strobe that arrives during a stretch reloads the full STRETCH count, which includes the cycle in which the old count would reach zero. The blink phase continues without a restart.
- R7: `led_speed_o` is 1 only when the link is up and `speed_100_i` is 1 (100 Mb/s). It is 0 for 10 Mb/s and 0 whenever the link is down.
- R8: Strobes are ignored while the link is down, and a link loss clears a running stretch. After the link returns, the indicator is steady 1 until a new strobe arrives.
- R9: Synchronous active-high `rst` clears the synchronizers and both timers and turns both indicators off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | Link valid status from the PHY |
| speed_100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| tx_pulse_i | input | 1 | One-cycle transmit activity strobe |
| rx_pulse_i | input | 1 | One-cycle receive activity strobe |
| led_link_o | output | 1 | Link/activity indicator, 1 = lit |
| led_speed_o | output | 1 | Speed indicator, 1 = lit |

## Verification
The bench uses a small clock setting, which gives an 80-cycle stretch and a 100-cycle half period. It predicts the link indicator every cycle through strobe trains, and it places strobes exactly STRETCH cycles apart. A design that let the timer lapse before reloading would show a one-cycle steady flash and a reset blink phase at that point. A design that blinked at the wrong rate would mismatch at the first toggle near cycle 103. Further tests inject strobes while the link is down and drop the link or assert reset in the middle of a stretch. A design that kept the stretch alive would show a dark indicator after relink instead of a steady one. The bench also checks the two-edge input latency, so a design with one synchronizer stage or three would fail there.

// File: rtl/netled_pkg.sv
package netled_pkg;

  // Number of clock cycles in a stretch of the given length in milliseconds.
  function automatic int stretch_cycles(input longint clk_hz, input longint ms);
    longint c;
    c = (clk_hz * ms) / 1000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // Number of clock cycles in one half period of the blink.
  function automatic int half_period_cycles(input longint clk_hz, input longint blink_hz);
    longint c;
    c = clk_hz / (2 * blink_hz);
    return (c < 1) ? 1 : int'(c);
  endfunction

  // Width needed to hold values 0..maxval, never below one bit.
  function automatic int count_width(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // Index of each status bit inside the synchronized bundle.
  typedef enum int {
    ST_LINK  = 0,
    ST_SPEED = 1,
    ST_TX    = 2,
    ST_RX    = 3
  } status_idx_e;

  localparam int STATUS_W = 4;

endpackage

// File: rtl/netled_sync.sv
module netled_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= async_i[b];
        stage2 <= stage1;
      end
    end
    assign sync_o[b] = stage2;
  end

endmodule

// File: rtl/netled_stretch.sv
module netled_stretch #(
  parameter int LENGTH = 80,
  parameter int CNT_W  = netled_pkg::count_width(LENGTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LENGTH);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= LOAD_VAL;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign remain_o = remain_q;
  assign busy_o   = (remain_q != '0);

endmodule

// File: rtl/netled_blink.sv
module netled_blink #(
  parameter int HALF  = 100,
  parameter int CNT_W = netled_pkg::count_width(HALF)
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic phase_o,
  output logic wrap_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] tick_q;
  logic             phase_q;

  assign wrap_o = (tick_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      tick_q  <= '0;
      phase_q <= 1'b0;
    end else if (wrap_o) begin
      tick_q  <= '0;
      phase_q <= ~phase_q;
    end else begin
      tick_q  <= tick_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/eth_led_driver.sv
module eth_led_driver #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int STRETCH_MS = 50,
  parameter int BLINK_HZ   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic link_up_i,
  input  logic speed_100_i,
  input  logic tx_pulse_i,
  input  logic rx_pulse_i,
  output logic led_link_o,
  output logic led_speed_o
);
  import netled_pkg::*;

  localparam int STRETCH_CYC = stretch_cycles(CLK_HZ, STRETCH_MS);
  localparam int HALF_CYC    = half_period_cycles(CLK_HZ, BLINK_HZ);
  localparam int SC_W        = count_width(STRETCH_CYC);

  logic [STATUS_W-1:0] raw_status;
  logic [STATUS_W-1:0] sync_status;

  assign raw_status[ST_LINK]  = link_up_i;
  assign raw_status[ST_SPEED] = speed_100_i;
  assign raw_status[ST_TX]    = tx_pulse_i;
  assign raw_status[ST_RX]    = rx_pulse_i;

  netled_sync #(.WIDTH(STATUS_W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_status),
    .sync_o  (sync_status)
  );

  // Named internal events for the checker.
  logic            link_s;
  logic            spd_s;
  logic            hit;
  logic            active;
  logic [SC_W-1:0] stretch_left;
  logic            blink_phase;
  logic            blink_wrap;

  assign link_s = sync_status[ST_LINK];
  assign spd_s  = sync_status[ST_SPEED];
  assign hit    = link_s & (sync_status[ST_TX] | sync_status[ST_RX]);

  netled_stretch #(.LENGTH(STRETCH_CYC), .CNT_W(SC_W)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (~link_s),
    .load_i   (hit),
    .remain_o (stretch_left),
    .busy_o   (active)
  );

  netled_blink #(.HALF(HALF_CYC)) u_blink (
    .clk     (clk),
    .rst     (rst),
    .run_i   (active),
    .phase_o (blink_phase),
    .wrap_o  (blink_wrap)
  );

  assign led_link_o  = link_s & (active ? blink_phase : 1'b1);
  assign led_speed_o = link_s & spd_s;

endmodule

// File: rtl/eth_led_driver_chk.sv
module eth_led_driver_chk #(
  parameter int SC_W    = 8,
  parameter int STRETCH = 80
) (
  input logic            clk,
  input logic            rst,
  input logic            link_s,
  input logic            hit,
  input logic            active,
  input logic [SC_W-1:0] stretch_left,
  input logic            blink_phase,
  input logic            blink_wrap,
  input logic            led_link_o,
  input logic            led_speed_o
);

  // R2
  link_off_chk: assert property (@(posedge clk) disable iff (rst)
    !link_s |-> !led_link_o);

  // R7
  speed_off_chk: assert property (@(posedge clk) disable iff (rst)
    !link_s |-> !led_speed_o);

  // R3
  steady_on_chk: assert property (@(posedge clk) disable iff (rst)
    (link_s && !active) |-> led_link_o);

  // R8
  down_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !link_s |=> !active);

  // R6
  reload_full_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (stretch_left == SC_W'(STRETCH)));

  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (active && link_s && !hit) |=> (stretch_left == $past(stretch_left) - 1'b1));

  // R5
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (active && blink_wrap) |=> (blink_phase != $past(blink_phase)));

  // R5
  hold_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !blink_wrap) |=> $stable(blink_phase));

  // R9
  reset_dark_chk: assert property (@(posedge clk)
    rst |=> (!led_link_o && !led_speed_o && !active));

endmodule

bind eth_led_driver eth_led_driver_chk #(
  .SC_W    (SC_W),
  .STRETCH (STRETCH_CYC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .link_s       (link_s),
  .hit          (hit),
  .active       (active),
  .stretch_left (stretch_left),
  .blink_phase  (blink_phase),
  .blink_wrap   (blink_wrap),
  .led_link_o   (led_link_o),
  .led_speed_o  (led_speed_o)
);

// File: tb/tb_eth_led_driver.sv
module tb_eth_led_driver;

  localparam int TB_CLK_HZ = 1600;
  localparam int TB_MS     = 50;
  localparam int TB_BLINK  = 8;
  // Expected cycle counts, worked out from the requirement formulas.
  localparam int S = TB_MS * TB_CLK_HZ / 1000;   // 80
  localparam int H = TB_CLK_HZ / TB_BLINK / 2;   // 100

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b0;
  logic spd = 1'b0;
  logic tx = 1'b0;
  logic rx = 1'b0;
  logic led_link;
  logic led_speed;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  eth_led_driver #(
    .CLK_HZ(TB_CLK_HZ), .STRETCH_MS(TB_MS), .BLINK_HZ(TB_BLINK)
  ) dut (
    .clk(clk), .rst(rst), .link_up_i(link_up), .speed_100_i(spd),
    .tx_pulse_i(tx), .rx_pulse_i(rx),
    .led_link_o(led_link), .led_speed_o(led_speed)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // Link indicator expected t edges after the first strobe was driven,
  // when the last reload happened at edge last_load (stretch continuous).
  function automatic logic exp_led(input int t, input int last_load);
    if (t < 3 || t >= last_load + S) return 1'b1;
    return (((t - 3) / H) % 2) == 1;
  endfunction

  // n strobes, gap cycles apart, starting now; link assumed up.
  task automatic burst(input int n, input int gap, input string req);
    int last_load;
    int stop;
    last_load = 3 + gap * (n - 1);
    stop = last_load + S + 10;
    for (int t = 0; t <= stop; t++) begin
      if (t > 0) chk(led_link, exp_led(t, last_load), req, $sformatf("burst t=%0d", t));
      if ((t % gap == 0) && (t / gap < n)) begin
        tx = ((t / gap) % 2 == 0) || ((t / gap) % 7 == 3);
        rx = ((t / gap) % 2 == 1) || ((t / gap) % 7 == 3);
      end else begin
        tx = 1'b0;
        rx = 1'b0;
      end
      step();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2;
    repeat (3) step();
    // R9 reset state
    chk(led_link, 1'b0, "R9", "reset link led");
    chk(led_speed, 1'b0, "R9", "reset speed led");
    rst = 1'b0;
    step();
    chk(led_link, 1'b0, "R2", "no link after reset");

    // R1 latency and R3 steady, R7 10 Mb/s
    link_up = 1'b1;
    step();
    chk(led_link, 1'b0, "R1", "link after one edge");
    step();
    chk(led_link, 1'b1, "R1", "link after two edges");
    chk(led_speed, 1'b0, "R7", "10M speed led");
    spd = 1'b1;
    step();
    chk(led_speed, 1'b0, "R1", "speed after one edge");
    step();
    chk(led_speed, 1'b1, "R7", "100M speed led");
    for (int i = 0; i < 10; i++) begin
      step();
      chk(led_link, 1'b1, "R3", "steady idle");
    end

    // R4 single strobe
    burst(1, 1, "R4");
    // R5 and R6 long train with restarts
    burst(45, 10, "R5");
    // R6 reload exactly at expiry
    burst(3, S, "R6");

    // R2 / R7 link loss
    link_up = 1'b0;
    step();
    step();
    chk(led_link, 1'b0, "R2", "link down");
    chk(led_speed, 1'b0, "R7", "speed forced off");
    // R8 strobes while down are ignored
    tx = 1'b1; rx = 1'b1;
    step();
    tx = 1'b0; rx = 1'b0;
    repeat (4) step();
    chk(led_link, 1'b0, "R2", "still down after strobe");
    link_up = 1'b1;
    step();
    step();
    for (int i = 0; i < 20; i++) begin
      chk(led_link, 1'b1, "R8", "no stretch from down-time strobe");
      step();
    end

    // R8 link loss clears a running stretch
    tx = 1'b1;
    step();
    tx = 1'b0;
    repeat (10) step();
    chk(led_link, 1'b0, "R4", "dark during stretch");
    link_up = 1'b0;
    step();
    step();
    chk(led_link, 1'b0, "R2", "drop mid stretch");
    link_up = 1'b1;
    step();
    step();
    for (int i = 0; i < 100; i++) begin
      chk(led_link, 1'b1, "R8", "stretch cleared by link loss");
      step();
    end

    // R9 reset mid stretch
    rx = 1'b1;
    step();
    rx = 1'b0;
    repeat (10) step();
    rst = 1'b1;
    step();
    chk(led_link, 1'b0, "R9", "reset link led mid stretch");
    chk(led_speed, 1'b0, "R9", "reset speed led mid stretch");
    rst = 1'b0;
    step();
    step();
    for (int i = 0; i < 90; i++) begin
      chk(led_link, 1'b1, "R9", "timer cleared by reset");
      step();
    end
    chk(led_speed, 1'b1, "R7", "speed after reset recovery");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule